// File: doc/BRIEF.md
# Configurable Serial Byte Shift Engine

The block is the master side of a three-wire synchronous serial link: a clock line it drives, a data-out line it drives, and a data-in line it samples. Each transfer moves exactly one byte. A one-cycle `start` launches the transfer and a one-cycle `done` closes it. The byte to send is taken from `tx_data` when the start is accepted. The received byte appears on `rx_data` in the same cycle as `done`.

A latched format word sets the bit order and the resting level of the data-out line. It also sets the clock edge on which outgoing bits change, the clock edge on which incoming bits are sampled, and optional inversion of each direction. These settings apply to both directions where that makes sense. A divider value sets the serial clock rate. Two mode inputs, captured with the start, choose transmit-only, receive-only or full-duplex operation.

The launch side behaves as a valid/ready pair. `start` is the valid and `en && !busy` is the ready. A start offered while not ready is dropped rather than held, so the caller must keep offering until `busy` rises. The result side has no back-pressure: `rx_data` holds its value until the next receiving transfer completes.

Top module: `spi_byte_engine`

## Requirements
- R1: A start is accepted only when `en`=1 and `busy`=0. `busy` then stays high for exactly 16*(DIV+1) cycles. `done` is high for one cycle, in the first cycle with `busy` low. A start offered in that `done` cycle is accepted.
- R2: `sclk` is 0 whenever `busy` is 0. During a transfer each half period lasts DIV+1 cycles, so the period is 2*(DIV+1) cycles. The first rising edge comes DIV+1 cycles after `busy` rises, and a transfer has 8 rising and 8 falling edges.
- R3: With `cfg_lsb_first`=1, bit 0 of the byte is the first on the line in both directions. With 0, bit 7 is first.
- R4: With `cfg_tx_pol`=0, `mosi` changes only on falling `sclk` edges. With 1, it changes only on rising edges after the first. In both cases the first bit is driven from the cycle after the start is accepted.
- R5: With `cfg_rx_pol`=0, `miso` is sampled on rising `sclk` edges. With 1, it is sampled on falling edges.
- R6: `cfg_tx_inv`=1 inverts every bit driven on `mosi` during a transfer. `cfg_rx_inv`=1 inverts every sampled `miso` bit before it is stored.
- R7: `mosi` equals the latched idle level whenever no transfer is running, and during the whole of a receive-only transfer (`mode_tx`=0).
- R8: With `mode_rx`=1, `rx_data` is loaded with the received byte at `done`. With `mode_rx`=0, `rx_data` keeps its previous value.
- R9: A `cfg_wr` while `busy`=1 changes nothing. The two polarity fields are latched only when `en`=0, while the other fields and the divider are latched whenever `busy`=0.
- R10: When `cfg_wr` and an accepted `start` fall in the same cycle, the transfer runs with the newly written format and divider.
- R11: After reset, `busy`, `done`, `sclk`, `mosi` and `rx_data` are 0, and all format fields and the divider are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; gates start and unlocks polarity writes when low |
| cfg_wr | input | 1 | Latch the cfg_* inputs |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_idle_lvl | input | 1 | Resting level of mosi |
| cfg_tx_pol | input | 1 | Edge on which outgoing bits change (0 falling, 1 rising) |
| cfg_rx_pol | input | 1 | Edge on which incoming bits are sampled (0 rising, 1 falling) |
| cfg_tx_inv | input | 1 | Invert outgoing bits |
| cfg_rx_inv | input | 1 | Invert incoming bits |
| cfg_div | input | DIV_W | Half-period length minus one, in system cycles |
| mode_tx | input | 1 | Transfer drives data out |
| mode_rx | input | 1 | Transfer stores received data |
| start | input | 1 | Launch request (valid) |
| tx_data | input | BITS | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | BITS | Last received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two functions can land in the same cycle: a configuration write and an accepted launch, and a completion pulse and the next launch. The bench drives `cfg_wr` and `start` on one edge with a changed bit order and divider. A serial peripheral model then decodes the line and checks that the byte follows the new format and that the edge spacing matches the new divider. The bench also raises `start` while `done` is still high. It checks that `busy` rises on the next edge and that both bytes are scored in order.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef struct packed {
    logic lsb_first;
    logic idle_lvl;
    logic tx_inv;
    logic rx_inv;
    logic tx_pol;
    logic rx_pol;
  } spi_fmt_t;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIV_W = 8,
  parameter int BITS  = 8,
  localparam int EDGES = 2 * BITS,
  localparam int IDX_W = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  output logic             run,
  output logic             sclk,
  output logic             edge_stb,
  output logic [IDX_W-1:0] edge_idx,
  output logic             fin
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(EDGES - 1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cnt      <= '0;
      edge_idx <= '0;
      sclk     <= 1'b0;
    end else if (go) begin
      run      <= 1'b1;
      cnt      <= '0;
      edge_idx <= '0;
      sclk     <= 1'b0;
    end else if (run) begin
      if (cnt == div) begin
        cnt      <= '0;
        sclk     <= ~sclk;
        edge_idx <= edge_idx + 1'b1;
        if (edge_idx == LAST) run <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    edge_stb = run && (cnt == div);
    fin      = edge_stb && (edge_idx == LAST);
  end

  // R2: clock rests low outside a transfer
  assert_sclk_rest_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sclk);
  // R2: a running transfer never leaves sclk low after an odd number of edges
  assert_sclk_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (sclk == edge_idx[0]));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int BITS = 8,
  localparam int EDGES = 2 * BITS,
  localparam int IDX_W = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BITS-1:0]  data,
  input  logic             lsb_first,
  input  logic             tx_pol,
  input  logic             edge_stb,
  input  logic [IDX_W-1:0] edge_idx,
  output logic             bit_out
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(EDGES - 1);

  logic [BITS-1:0] sh;
  logic            adv;

  // polarity 1: advance on rising edges after the first; 0: on falling edges but the last
  always_comb begin
    if (tx_pol) adv = edge_stb && !edge_idx[0] && (edge_idx != '0);
    else        adv = edge_stb &&  edge_idx[0] && (edge_idx != LAST);
    bit_out = lsb_first ? sh[0] : sh[BITS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh <= '0;
    else if (load) sh <= data;
    else if (adv) sh <= lsb_first ? (sh >> 1) : (sh << 1);
  end

  // R4: the register never moves on an edge of the wrong direction
  assert_tx_edge_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && !load && (edge_idx[0] == tx_pol)) |=> $stable(sh));
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int BITS = 8,
  localparam int EDGES = 2 * BITS,
  localparam int IDX_W = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             miso,
  input  logic             rx_inv,
  input  logic             rx_pol,
  input  logic             lsb_first,
  input  logic             edge_stb,
  input  logic [IDX_W-1:0] edge_idx,
  output logic [BITS-1:0]  nxt
);
  logic [BITS-1:0] sh;
  logic            take;
  logic            b;

  // polarity 0 samples on rising (even index), 1 on falling (odd index)
  always_comb begin
    take = edge_stb && (edge_idx[0] == rx_pol);
    b    = miso ^ rx_inv;
    if (!take)          nxt = sh;
    else if (lsb_first) nxt = {b, sh[BITS-1:1]};
    else                nxt = {sh[BITS-2:0], b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh <= '0;
    else if (clr) sh <= '0;
    else          sh <= nxt;
  end

  // R5: samples are taken only on the selected edge direction
  assert_rx_edge_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && !clr && (edge_idx[0] != rx_pol)) |=> $stable(sh));
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DIV_W = 8,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_wr,
  input  logic             cfg_lsb_first,
  input  logic             cfg_idle_lvl,
  input  logic             cfg_tx_pol,
  input  logic             cfg_rx_pol,
  input  logic             cfg_tx_inv,
  input  logic             cfg_rx_inv,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             mode_tx,
  input  logic             mode_rx,
  input  logic             start,
  input  logic [BITS-1:0]  tx_data,
  output logic             busy,
  output logic             done,
  output logic [BITS-1:0]  rx_data,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  import spi_eng_pkg::*;
  localparam int IDX_W = $clog2(2 * BITS);

  spi_fmt_t         fmt_q;
  logic [DIV_W-1:0] div_q;
  logic             run, go, fin, edge_stb, tx_bit;
  logic [IDX_W-1:0] edge_idx;
  logic             txm, rxm;
  logic [BITS-1:0]  rx_nxt;

  assign go   = start && en && !run;
  assign busy = run;

  // format latch: whole word when idle, polarities only with the engine disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0;
      div_q <= '0;
    end else if (cfg_wr && !run) begin
      fmt_q.lsb_first <= cfg_lsb_first;
      fmt_q.idle_lvl  <= cfg_idle_lvl;
      fmt_q.tx_inv    <= cfg_tx_inv;
      fmt_q.rx_inv    <= cfg_rx_inv;
      div_q           <= cfg_div;
      if (!en) begin
        fmt_q.tx_pol <= cfg_tx_pol;
        fmt_q.rx_pol <= cfg_rx_pol;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txm     <= 1'b0;
      rxm     <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= fin;
      if (go) begin
        txm <= mode_tx;
        rxm <= mode_rx;
      end
      if (fin && rxm) rx_data <= rx_nxt;
    end
  end

  always_comb mosi = (run && txm) ? (tx_bit ^ fmt_q.tx_inv) : fmt_q.idle_lvl;

  spi_sclk_gen #(.DIV_W(DIV_W), .BITS(BITS)) u_clk (
    .clk(clk), .rst_n(rst_n), .go(go), .div(div_q), .run(run), .sclk(sclk),
    .edge_stb(edge_stb), .edge_idx(edge_idx), .fin(fin));

  spi_tx_shift #(.BITS(BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(go), .data(tx_data),
    .lsb_first(fmt_q.lsb_first), .tx_pol(fmt_q.tx_pol),
    .edge_stb(edge_stb), .edge_idx(edge_idx), .bit_out(tx_bit));

  spi_rx_shift #(.BITS(BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(go), .miso(miso), .rx_inv(fmt_q.rx_inv),
    .rx_pol(fmt_q.rx_pol), .lsb_first(fmt_q.lsb_first),
    .edge_stb(edge_stb), .edge_idx(edge_idx), .nxt(rx_nxt));

  // R1: completion is a single-cycle pulse
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: completion coincides with the first idle cycle
  assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R1: an offered start while ready always launches
  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en && !busy) |=> busy);
  // R9: the format stays frozen for the length of a transfer
  assert_fmt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fmt_q) && $stable(div_q)));
  // R9: polarities never move while the engine is enabled
  assert_pol_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable({fmt_q.tx_pol, fmt_q.rx_pol}));
  // R7: receive-only transfers keep the data-out line parked
  assert_rx_only_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !txm) |-> $stable(mosi));
endmodule

// File: tb/spi_byte_engine_tb.sv
module spi_byte_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cfg_wr = 1'b0;
  logic c_lsb = 0, c_idle = 0, c_txp = 0, c_rxp = 0, c_txi = 0, c_rxi = 0;
  logic [7:0] c_div = 8'd0;
  logic mode_tx = 0, mode_rx = 0, start = 0;
  logic [7:0] tx_data = 8'd0;
  logic busy, done, sclk, mosi;
  logic miso = 1'b0;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  spi_byte_engine u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr),
    .cfg_lsb_first(c_lsb), .cfg_idle_lvl(c_idle), .cfg_tx_pol(c_txp),
    .cfg_rx_pol(c_rxp), .cfg_tx_inv(c_txi), .cfg_rx_inv(c_rxi), .cfg_div(c_div),
    .mode_tx(mode_tx), .mode_rx(mode_rx), .start(start), .tx_data(tx_data),
    .busy(busy), .done(done), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso));

  // bench model of the latched format
  logic m_lsb = 0, m_idle = 0, m_txp = 0, m_rxp = 0, m_txi = 0, m_rxi = 0;
  int   m_div = 0;
  logic [7:0] m_rx = 8'd0;
  logic [7:0] sl_byte = 8'd0;
  logic [15:0] exp_q[$];
  int n_chk = 0, n_fail = 0, done_cnt = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic sbit(input int k);
    if (k > 7) return 1'b0;
    return m_lsb ? sl_byte[k] : sl_byte[7-k];
  endfunction

  // monitor: serial peripheral model and scoreboard
  logic p_sclk = 0, p_mosi = 0, p_busy = 0;
  int sl_k, capn, rises, cyc, busy_cyc, first_rise, per;
  logic [7:0] cap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !p_busy) begin
        sl_k = 0; miso = sbit(0); capn = 0; cap = 8'd0;
        rises = 0; cyc = 0; busy_cyc = 1; first_rise = -1; per = -1;
      end else if (busy) begin
        cyc++; busy_cyc++;
      end
      if (sclk && !p_sclk) begin
        if (rises == 0) first_rise = cyc;
        if (rises == 1) per = cyc - first_rise;
        if (m_txp == 1'b0 && capn < 8) begin
          cap[m_lsb ? capn : 7-capn] = p_mosi; capn++;
        end
        if (m_rxp == 1'b1 && rises >= 1) begin sl_k++; miso = sbit(sl_k); end
        rises++;
      end
      if (!sclk && p_sclk) begin
        if (m_txp == 1'b1 && capn < 8) begin
          cap[m_lsb ? capn : 7-capn] = p_mosi; capn++;
        end
        if (m_rxp == 1'b0) begin sl_k++; miso = sbit(sl_k); end
      end
      if (done) begin
        done_cnt++;
        if (exp_q.size() == 0) chk("R1 unexpected done", 1, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk("R3/R4/R6/R7 mosi byte", cap, e[15:8]);
          chk("R3/R5/R6/R8 rx_data", rx_data, e[7:0]);
          chk("R2 first rise", first_rise, m_div + 1);
          chk("R2 period", per, 2 * (m_div + 1));
          chk("R1 busy length", busy_cyc, 16 * (m_div + 1));
        end
      end
      p_sclk = sclk; p_mosi = mosi; p_busy = busy;
    end
  end

  task automatic put_cfg(input logic l, i, tp, rp, ti, ri, input int d);
    c_lsb = l; c_idle = i; c_txp = tp; c_rxp = rp; c_txi = ti; c_rxi = ri;
    c_div = 8'(d);
  endtask

  task automatic model_cfg();
    if (!busy) begin
      m_lsb = c_lsb; m_idle = c_idle; m_txi = c_txi; m_rxi = c_rxi; m_div = c_div;
      if (!en) begin m_txp = c_txp; m_rxp = c_rxp; end
    end
  endtask

  task automatic set_cfg(input logic l, i, tp, rp, ti, ri, input int d);
    @(negedge clk);
    put_cfg(l, i, tp, rp, ti, ri, d);
    model_cfg();
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // called at a negedge; pushes the expectation and pulses start
  task automatic launch(input logic [7:0] tx, sl, input logic mt, mr, input logic wcfg);
    logic [7:0] em;
    if (wcfg) model_cfg();
    sl_byte = sl;
    em = mt ? (tx ^ {8{m_txi}}) : {8{m_idle}};
    if (mr) m_rx = sl ^ {8{m_rxi}};
    exp_q.push_back({em, m_rx});
    tx_data = tx; mode_tx = mt; mode_rx = mr; start = 1'b1; cfg_wr = wcfg;
    @(negedge clk);
    start = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, sl, input logic mt, mr);
    @(negedge clk);
    launch(tx, sl, mt, mr, 1'b0);
    wait_done();
    @(negedge clk);
    chk("R7 idle mosi after transfer", mosi, m_idle);
    chk("R2 sclk low when idle", sclk, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int dc;
    repeat (4) @(negedge clk);
    chk("R11 busy", busy, 0); chk("R11 done", done, 0); chk("R11 sclk", sclk, 0);
    chk("R11 mosi", mosi, 0); chk("R11 rx_data", rx_data, 0);
    rst_n = 1'b1;
    set_cfg(0, 1, 0, 0, 0, 0, 1);
    // R1: start ignored while disabled
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 start ignored with en=0", busy, 0);
    en = 1'b1;
    xfer(8'hA5, 8'h3C, 1, 1);
    set_cfg(1, 1, 0, 0, 1, 0, 1);           // R3 lsb first, R6 tx inversion
    xfer(8'h96, 8'hC1, 1, 1);
    en = 1'b0;
    set_cfg(0, 0, 1, 1, 0, 1, 2);           // R4/R5 both polarities 1, R6 rx inversion
    en = 1'b1;
    xfer(8'h0F, 8'h81, 1, 1);
    en = 1'b0;
    set_cfg(1, 1, 0, 1, 0, 0, 0);           // mixed polarities, divider 0
    en = 1'b1;
    xfer(8'hE7, 8'h5A, 1, 1);
    xfer(8'h00, 8'h33, 0, 1);               // R7 receive-only keeps idle level
    xfer(8'h12, 8'h77, 1, 0);               // R8 transmit-only keeps rx_data
    chk("R8 rx_data held", rx_data, 8'h33);
    set_cfg(1, 1, 1, 0, 0, 0, 0);           // R9 polarity write with en=1 ignored
    xfer(8'hC3, 8'h69, 1, 1);
    // R9 configuration write while busy ignored
    @(negedge clk); launch(8'h5C, 8'hA0, 1, 1, 1'b0);
    repeat (3) @(negedge clk);
    put_cfg(0, 0, 0, 0, 1, 1, 3); model_cfg(); cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    wait_done();
    xfer(8'h3A, 8'hB4, 1, 1);
    // R1 start while busy ignored
    dc = done_cnt;
    @(negedge clk); launch(8'h71, 8'h2E, 1, 1, 1'b0);
    repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk("R1 single done for busy restart", done_cnt - dc, 1);
    chk("R1 idle after ignored start", busy, 0);
    // R10 format write and start in the same cycle
    @(negedge clk);
    put_cfg(0, 0, 0, 0, 1, 0, 2);
    launch(8'hD2, 8'h4B, 1, 1, 1'b1);
    wait_done();
    // R1 start offered in the done cycle
    @(negedge clk); launch(8'h18, 8'hE1, 1, 1, 1'b0);
    wait_done();
    launch(8'h9B, 8'h06, 1, 1, 1'b0);
    chk("R1 launch in done cycle", busy, 1);
    wait_done();
    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule